// File: doc/BRIEF.md
# Circular Post-Modify Address Generator

This block produces data-memory addresses for register-indirect accesses that modify the pointer after use. It keeps several register sets, four by default. Each set has an index (the pointer), a signed modify step, a window length and a window base. A request on an access port returns the selected set's current index as the address. In the same edge, that index is advanced by the modify step.

When the length is non-zero, the new index is folded back into the window that starts at base and spans length bytes. This is how a ring of filter taps or delay-line samples is walked without any software bookkeeping. A length of zero turns the fold off, and the index then moves linearly.

There are two access ports, so two operands can be fetched in one cycle. All addresses are byte addresses. Software loads the registers through a single write port.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset, both valid outputs and both address outputs are 0, and every register of every set is 0, so an access to any set returns address 0.
- R2: A request on port A or B in cycle t drives that port's valid high in cycle t+1. The address in cycle t+1 is the selected set's index as it stood in cycle t, and the set's index becomes index plus modify, with modify read as a signed value.
- R3: With a non-zero length, when index plus modify is greater than or equal to base plus length, the stored index is index plus modify minus length.
- R4: With a non-zero length, when index plus modify is below base, the stored index is index plus modify plus length.
- R5: With a length of 0, the stored index is index plus modify modulo 2^32, with no folding.
- R6: A register write uses a field code: 0 is index, 1 is modify, 2 is length, 3 is base. A write of the base field also loads the same set's index with the written value.
- R7: Requests on both ports to different sets in the same cycle are both served, and each set is updated by its own modify step.
- R8: When both ports request the same set in the same cycle, both return the same address, and the set advances only once, by port A's update.
- R9: A register write to a set's index or base in the same cycle as an access to that set returns the old index as the address, and the written value takes priority over the post-modify update.
- R10: In a cycle after no request on a port, that port's valid is 0 and its address holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_set | input | 2 | Set targeted by the write |
| wr_field | input | 2 | Field code: 0 index, 1 modify, 2 length, 3 base |
| wr_data | input | 32 | Write value |
| a_req | input | 1 | Access request, port A |
| a_set | input | 2 | Set used by port A |
| b_req | input | 1 | Access request, port B |
| b_set | input | 2 | Set used by port B |
| a_addr | output | 32 | Registered address, port A |
| a_valid | output | 1 | Port A address is fresh |
| b_addr | output | 32 | Registered address, port B |
| b_valid | output | 1 | Port B address is fresh |

## Verification
Each register set is walked across several accesses with different step patterns:
- a forward step inside a large window, which separates plain post-modify from any folding;
- forward steps that cross the top of the window, including lengths that are not a multiple of the step, which exposes an off-by-one in the upper comparison;
- backward steps through the window floor, one byte at a time and in 4-byte strides, which exercises the add-back path;
- zero-length windows with positive and negative steps, including a pass through address 0, which show that folding is really disabled.

Directed cases then cover two ports on two sets, two ports on one set, and a write racing an access. These show which update wins when two actions target the same set.

// File: rtl/circ_addr_pkg.sv
package circ_addr_pkg;
  typedef enum logic [1:0] {
    FLD_INDEX  = 2'd0,
    FLD_MODIFY = 2'd1,
    FLD_LENGTH = 2'd2,
    FLD_BASE   = 2'd3
  } field_e;
endpackage

// File: rtl/circ_wrap_unit.sv
module circ_wrap_unit #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_idx,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] win_len,
  input  logic [AW-1:0] win_base,
  output logic [AW-1:0] nxt_idx
);
  localparam int EW = AW + 2;

  logic signed [EW-1:0] sum_x, lo_x, hi_x, len_x, fold_x;

  always_comb begin
    sum_x  = $signed({2'b00, cur_idx}) + $signed({{2{step[AW-1]}}, step});
    lo_x   = $signed({2'b00, win_base});
    len_x  = $signed({2'b00, win_len});
    hi_x   = lo_x + len_x;
    fold_x = sum_x;
    if (win_len != '0) begin
      if (sum_x >= hi_x)     fold_x = sum_x - len_x;
      else if (sum_x < lo_x) fold_x = sum_x + len_x;
    end
    nxt_idx = fold_x[AW-1:0];
  end
endmodule

// File: rtl/circ_reg_bank.sv
module circ_reg_bank #(
  parameter int NSETS = 4,
  parameter int AW    = 32,
  parameter int SW    = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_set,
  input  logic [1:0]    wr_field,
  input  logic [AW-1:0] wr_data,
  input  logic          upd_a_en,
  input  logic [SW-1:0] upd_a_set,
  input  logic [AW-1:0] upd_a_val,
  input  logic          upd_b_en,
  input  logic [SW-1:0] upd_b_set,
  input  logic [AW-1:0] upd_b_val,
  output logic [AW-1:0] idx_q  [NSETS],
  output logic [AW-1:0] mod_q  [NSETS],
  output logic [AW-1:0] len_q  [NSETS],
  output logic [AW-1:0] base_q [NSETS]
);
  import circ_addr_pkg::*;

  field_e fld;
  assign fld = field_e'(wr_field);

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    logic hit_a, hit_b, hit_w;
    assign hit_a = upd_a_en && (upd_a_set == SW'(g));
    assign hit_b = upd_b_en && (upd_b_set == SW'(g));
    assign hit_w = wr_en    && (wr_set    == SW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        idx_q[g]  <= '0;
        mod_q[g]  <= '0;
        len_q[g]  <= '0;
        base_q[g] <= '0;
      end else begin
        // Lowest priority first: port B, then port A, then software write.
        if (hit_b && !hit_a) idx_q[g] <= upd_b_val;
        if (hit_a)           idx_q[g] <= upd_a_val;
        if (hit_w) begin
          case (fld)
            FLD_INDEX:  idx_q[g] <= wr_data;
            FLD_MODIFY: mod_q[g] <= wr_data;
            FLD_LENGTH: len_q[g] <= wr_data;
            FLD_BASE: begin
              base_q[g] <= wr_data;
              idx_q[g]  <= wr_data;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/circ_port.sv
module circ_port #(
  parameter int NSETS = 4,
  parameter int AW    = 32,
  parameter int SW    = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [SW-1:0] sel,
  input  logic [AW-1:0] idx_q  [NSETS],
  input  logic [AW-1:0] mod_q  [NSETS],
  input  logic [AW-1:0] len_q  [NSETS],
  input  logic [AW-1:0] base_q [NSETS],
  output logic [AW-1:0] addr_q,
  output logic          valid_q,
  output logic          upd_en,
  output logic [SW-1:0] upd_set,
  output logic [AW-1:0] upd_val
);
  logic [AW-1:0] cur_idx, cur_mod, cur_len, cur_base;

  assign cur_idx  = idx_q[sel];
  assign cur_mod  = mod_q[sel];
  assign cur_len  = len_q[sel];
  assign cur_base = base_q[sel];

  circ_wrap_unit #(.AW(AW)) u_wrap (
    .cur_idx  (cur_idx),
    .step     (cur_mod),
    .win_len  (cur_len),
    .win_base (cur_base),
    .nxt_idx  (upd_val)
  );

  assign upd_en  = req;
  assign upd_set = sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= req;
      if (req) addr_q <= cur_idx;
    end
  end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int NSETS = 4,
  parameter int AW    = 32,
  parameter int SW    = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_set,
  input  logic [1:0]    wr_field,
  input  logic [AW-1:0] wr_data,
  input  logic          a_req,
  input  logic [SW-1:0] a_set,
  input  logic          b_req,
  input  logic [SW-1:0] b_set,
  output logic [AW-1:0] a_addr,
  output logic          a_valid,
  output logic [AW-1:0] b_addr,
  output logic          b_valid
);
  logic [AW-1:0] idx_q [NSETS];
  logic [AW-1:0] mod_q [NSETS];
  logic [AW-1:0] len_q [NSETS];
  logic [AW-1:0] base_q [NSETS];

  logic          ua_en, ub_en;
  logic [SW-1:0] ua_set, ub_set;
  logic [AW-1:0] ua_val, ub_val;

  circ_reg_bank #(.NSETS(NSETS), .AW(AW), .SW(SW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_set    (wr_set),
    .wr_field  (wr_field),
    .wr_data   (wr_data),
    .upd_a_en  (ua_en),
    .upd_a_set (ua_set),
    .upd_a_val (ua_val),
    .upd_b_en  (ub_en),
    .upd_b_set (ub_set),
    .upd_b_val (ub_val),
    .idx_q     (idx_q),
    .mod_q     (mod_q),
    .len_q     (len_q),
    .base_q    (base_q)
  );

  circ_port #(.NSETS(NSETS), .AW(AW), .SW(SW)) u_port_a (
    .clk     (clk),
    .rst     (rst),
    .req     (a_req),
    .sel     (a_set),
    .idx_q   (idx_q),
    .mod_q   (mod_q),
    .len_q   (len_q),
    .base_q  (base_q),
    .addr_q  (a_addr),
    .valid_q (a_valid),
    .upd_en  (ua_en),
    .upd_set (ua_set),
    .upd_val (ua_val)
  );

  circ_port #(.NSETS(NSETS), .AW(AW), .SW(SW)) u_port_b (
    .clk     (clk),
    .rst     (rst),
    .req     (b_req),
    .sel     (b_set),
    .idx_q   (idx_q),
    .mod_q   (mod_q),
    .len_q   (len_q),
    .base_q  (base_q),
    .addr_q  (b_addr),
    .valid_q (b_valid),
    .upd_en  (ub_en),
    .upd_set (ub_set),
    .upd_val (ub_val)
  );
endmodule

// File: rtl/circ_addr_gen_chk.sv
module circ_addr_gen_chk #(
  parameter int AW = 32,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          a_req,
  input logic [SW-1:0] a_set,
  input logic          b_req,
  input logic [SW-1:0] b_set,
  input logic [AW-1:0] a_addr,
  input logic          a_valid,
  input logic [AW-1:0] b_addr,
  input logic          b_valid
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!a_valid && !b_valid && a_addr == '0 && b_addr == '0));

  assert_a_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    a_req |=> a_valid);

  assert_b_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    b_req |=> b_valid);

  assert_same_set_same_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (a_req && b_req && a_set == b_set) |=> (a_addr == b_addr));

  assert_a_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !a_req |=> (!a_valid && $stable(a_addr)));

  assert_b_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !b_req |=> (!b_valid && $stable(b_addr)));
endmodule

bind circ_addr_gen circ_addr_gen_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .a_req   (a_req),
  .a_set   (a_set),
  .b_req   (b_req),
  .b_set   (b_set),
  .a_addr  (a_addr),
  .a_valid (a_valid),
  .b_addr  (b_addr),
  .b_valid (b_valid)
);

// File: tb/circ_addr_gen_test.sv
module circ_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_set = '0;
  logic [1:0]  wr_field = '0;
  logic [31:0] wr_data = '0;
  logic        a_req = 1'b0;
  logic [1:0]  a_set = '0;
  logic        b_req = 1'b0;
  logic [1:0]  b_set = '0;
  logic [31:0] a_addr, b_addr;
  logic        a_valid, b_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  circ_addr_gen uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_set(wr_set), .wr_field(wr_field),
    .wr_data(wr_data), .a_req(a_req), .a_set(a_set), .b_req(b_req), .b_set(b_set),
    .a_addr(a_addr), .a_valid(a_valid), .b_addr(b_addr), .b_valid(b_valid)
  );

  typedef struct packed {
    logic [7:0]  rq;
    logic [1:0]  set;
    logic [31:0] base;
    logic [31:0] len;
    logic [31:0] step;
    logic [31:0] idx;
    logic [31:0] e0;
    logic [31:0] e1;
    logic [31:0] e2;
    logic [31:0] e3;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    // R2: plain forward step inside a wide window
    '{8'd2, 2'd0, 32'h100, 32'h40, 32'd4, 32'h100, 32'h100, 32'h104, 32'h108, 32'h10C},
    // R3: crossing the window top at an exact multiple
    '{8'd3, 2'd1, 32'h200, 32'd16, 32'd4, 32'h208, 32'h208, 32'h20C, 32'h200, 32'h204},
    // R4: stride -4 through the window floor
    '{8'd4, 2'd2, 32'h300, 32'd12, 32'hFFFF_FFFC, 32'h304, 32'h304, 32'h300, 32'h308, 32'h304},
    // R3: length not a multiple of the step
    '{8'd3, 2'd3, 32'h10, 32'd10, 32'd3, 32'h16, 32'h16, 32'h19, 32'h12, 32'h15},
    // R5: zero length, forward linear
    '{8'd5, 2'd0, 32'hFF0, 32'd0, 32'h20, 32'hFF0, 32'hFF0, 32'h1010, 32'h1030, 32'h1050},
    // R4: four-entry ring walked backwards by one
    '{8'd4, 2'd1, 32'h0, 32'd4, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h3, 32'h2, 32'h1},
    // R3: four-entry ring walked forwards, last location returns to first
    '{8'd3, 2'd2, 32'h0, 32'd4, 32'd1, 32'h2, 32'h2, 32'h3, 32'h0, 32'h1},
    // R5: zero length, backward through address zero
    '{8'd5, 2'd3, 32'h0, 32'd0, 32'hFFFF_FFF8, 32'h8, 32'h8, 32'h0, 32'hFFFF_FFF8, 32'hFFFF_FFF0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [1:0] f, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_set = s; wr_field = f; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic acc_a(input logic [1:0] s, output logic [31:0] got);
    @(negedge clk);
    a_req = 1'b1; a_set = s;
    @(negedge clk);
    a_req = 1'b0;
    got = a_valid ? a_addr : 32'hDEAD_BEEF;
  endtask

  initial begin
    logic [31:0] got;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 a_valid", {31'b0, a_valid}, 32'd0);
    check("R1 b_valid", {31'b0, b_valid}, 32'd0);
    check("R1 a_addr", a_addr, 32'd0);
    rst = 1'b0;
    acc_a(2'd2, got);
    check("R1 set2 index", got, 32'd0);
    acc_a(2'd2, got);
    check("R1 set2 modify zero", got, 32'd0);

    for (int v = 0; v < NV; v++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VECS[v].rq, v);
      wr(VECS[v].set, 2'd3, VECS[v].base);
      wr(VECS[v].set, 2'd2, VECS[v].len);
      wr(VECS[v].set, 2'd1, VECS[v].step);
      wr(VECS[v].set, 2'd0, VECS[v].idx);
      acc_a(VECS[v].set, got); check(tg, got, VECS[v].e0);
      acc_a(VECS[v].set, got); check(tg, got, VECS[v].e1);
      acc_a(VECS[v].set, got); check(tg, got, VECS[v].e2);
      acc_a(VECS[v].set, got); check(tg, got, VECS[v].e3);
    end

    // R6: base write loads index
    wr(2'd1, 2'd3, 32'h500);
    acc_a(2'd1, got);
    check("R6 base loads index", got, 32'h500);

    // R7: two ports, two sets
    wr(2'd0, 2'd3, 32'h0); wr(2'd0, 2'd2, 32'd8); wr(2'd0, 2'd1, 32'd2); wr(2'd0, 2'd0, 32'd6);
    wr(2'd1, 2'd3, 32'h40); wr(2'd1, 2'd2, 32'd8); wr(2'd1, 2'd1, 32'hFFFF_FFFE);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      a_req = 1'b1; a_set = 2'd0; b_req = 1'b1; b_set = 2'd1;
      @(negedge clk);
      a_req = 1'b0; b_req = 1'b0;
      check("R7 port A", a_addr, (k == 0) ? 32'd6 : 32'd0);
      check("R7 port B", b_addr, (k == 0) ? 32'h40 : 32'h46);
      check("R7 B valid", {31'b0, b_valid}, 32'd1);
    end

    // R8: both ports on set 0 (index now 2)
    @(negedge clk);
    a_req = 1'b1; a_set = 2'd0; b_req = 1'b1; b_set = 2'd0;
    @(negedge clk);
    a_req = 1'b0; b_req = 1'b0;
    check("R8 port A", a_addr, 32'd2);
    check("R8 port B", b_addr, 32'd2);
    acc_a(2'd0, got);
    check("R8 single advance", got, 32'd4);

    // R9: index write racing an access on set 1 (index now 0x44)
    @(negedge clk);
    a_req = 1'b1; a_set = 2'd1;
    wr_en = 1'b1; wr_set = 2'd1; wr_field = 2'd0; wr_data = 32'h42;
    @(negedge clk);
    a_req = 1'b0; wr_en = 1'b0;
    check("R9 old index returned", a_addr, 32'h44);
    acc_a(2'd1, got);
    check("R9 write wins", got, 32'h42);

    // R10: idle cycle keeps address, drops valid
    held = a_addr;
    @(negedge clk);
    check("R10 valid low", {31'b0, a_valid}, 32'd0);
    check("R10 addr held", a_addr, held);

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule